// File: doc/BRIEF.md
# HDLC Transmit Framer with 56k Line Packing

This block turns a frame, delivered as a stream of bytes with start-of-frame and end-of-frame markers, into a bit-stuffed HDLC line stream. It then packs that stream into output octets. Each frame is wrapped in an opening and a closing 0x7E flag. A 16-bit frame check sequence is appended. A zero is inserted after every run of five consecutive ones in the data and check fields. The last partial octet is padded with ones and followed by one extra all-ones octet.

Two packing modes exist, and the mode is chosen per frame. In 64k mode each output octet holds eight line bits. In 56k mode each output octet holds seven line bits in its low part, and its top bit is always 1. Line bits go out least significant bit first and are shifted into the octet from the top, so the earliest bit lands in bit 0. The block produces one line bit per clock while a frame is in progress. A completed octet appears with a one-cycle valid strobe. Between strobes the octet output rests at 0xFF.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, and on every cycle in which `oct_valid` is low, `oct_data` reads 0xFF. Directly after reset, `byte_ready` is high and `oct_valid` is low.
- R2: Every frame begins with the flag 0x7E, sent without stuffing. In 64k mode the first octet of a frame is 0x7E.
- R3: Each data byte is sent bit 0 first. Line bits fill an octet from bit 0 upward in the order they are sent.
- R4: After five consecutive 1 bits in the data or check fields, a 0 bit is inserted and the run count restarts. A 0 bit also restarts the count. Flag bits are never stuffed, but a zero still owed from the last check bit goes out before the closing flag.
- R5: The check field is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, computed over the data bytes only. It is inverted and sent low byte first, then high byte, and it is stuffed like data.
- R6: With `mode_56k` low at frame start, an octet is emitted after every 8 line bits.
- R7: With `mode_56k` high at frame start, an octet is emitted after every 7 line bits. The bits occupy [6:0] and bit 7 is 1. The mode is sampled only when a frame is accepted.
- R8: If the closing flag leaves a partial octet, its unused upper positions are filled with 1s. One extra 0xFF octet follows. When the stream ends on an octet boundary, neither is sent.
- R9: A byte is taken when `byte_valid` and `byte_ready` are both high. A new frame is taken only after the previous frame's last octet has been emitted, and `byte_ready` stays low until then.
- R10: Pauses in `byte_valid` between the bytes of a frame do not change the emitted octet sequence.
- R11: An inserted stuffing bit counts toward the 7- or 8-bit octet boundary.
- R12: While idle, a byte offered without `byte_sof` is dropped and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_56k | input | 1 | Packing mode for the next frame: 1 = 7 bits per octet |
| byte_valid | input | 1 | A frame byte is offered |
| byte_sof | input | 1 | Offered byte is the first of a frame |
| byte_eof | input | 1 | Offered byte is the last of a frame |
| byte_data | input | 8 | Frame byte |
| byte_ready | output | 1 | The block takes the offered byte this cycle |
| oct_valid | output | 1 | One-cycle strobe for an emitted octet |
| oct_data | output | 8 | Emitted octet, 0xFF when no strobe |

## Verification
Most state faults in this block show up as a shifted or corrupted bit in the packed octets. A wrong run counter, bit index or packing count breaks the octet alignment. That error is visible in the first octet that follows the fault, and it carries through the rest of the frame. A fault in the check register or in the mode latch shows only in the check-field octets or in bit 7, so those octets are compared against an independent bit-level model of each whole frame. Handshake faults are caught by timing when a second frame's first byte is taken relative to the last octet of the first frame.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter logic [7:0]  FLAG      = 8'h7E,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [15:0] CRC_SEED  = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_56k,
  input  logic       byte_valid,
  input  logic       byte_sof,
  input  logic       byte_eof,
  input  logic [7:0] byte_data,
  output logic       byte_ready,
  output logic       oct_valid,
  output logic [7:0] oct_data
);
  localparam logic [2:0] RUN_MAX = 3'd5;
  localparam logic [3:0] OCT8    = 4'd8;
  localparam logic [3:0] OCT7    = 4'd7;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_LOAD, S_DATA, S_CHK_LO, S_CHK_HI, S_CLOSE, S_PAD, S_EXTRA
  } phase_t;

  phase_t      st;
  logic        m56;
  logic [7:0]  sh, first_byte;
  logic [2:0]  bi, ones;
  logic [15:0] crc;
  logic        last_byte;
  logic [7:0]  acc;
  logic [3:0]  cnt;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  logic       emit, stuff, step, last, lbit, full, counted;
  logic [3:0] cnt_n;
  logic [7:0] acc_n, pad_val;

  assign emit    = (st == S_OPEN) || (st == S_DATA) || (st == S_CHK_LO) ||
                   (st == S_CHK_HI) || (st == S_CLOSE);
  assign counted = (st == S_DATA) || (st == S_CHK_LO) || (st == S_CHK_HI);
  assign stuff   = emit && (ones == RUN_MAX);
  assign step    = emit && !stuff;
  assign last    = step && (bi == 3'd7);
  assign lbit    = stuff ? 1'b0 : sh[0];
  assign cnt_n   = cnt + 4'd1;
  assign acc_n   = {lbit, acc[7:1]};
  assign full    = m56 ? (cnt_n == OCT7) : (cnt_n == OCT8);
  assign pad_val = (acc >> (OCT8 - cnt)) | (8'hFF << cnt);
  assign byte_ready = (st == S_IDLE) || (st == S_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  m56 <= 1'b0;  sh <= '0;  first_byte <= '0;
      bi <= '0;  ones <= '0;  crc <= CRC_SEED;  last_byte <= 1'b0;
      acc <= '0;  cnt <= '0;  oct_valid <= 1'b0;  oct_data <= 8'hFF;
    end else begin
      oct_valid <= 1'b0;
      oct_data  <= 8'hFF;
      if (emit) begin
        acc <= acc_n;
        if (full) begin
          oct_valid <= 1'b1;
          oct_data  <= m56 ? {1'b1, acc_n[7:1]} : acc_n;
          cnt       <= '0;
        end else begin
          cnt <= cnt_n;
        end
        if (stuff) begin
          ones <= '0;
        end else begin
          sh   <= {1'b0, sh[7:1]};
          bi   <= bi + 3'd1;
          ones <= (counted && sh[0]) ? ones + 3'd1 : 3'd0;
        end
      end
      case (st)
        S_IDLE: if (byte_valid && byte_sof) begin
          m56 <= mode_56k;  first_byte <= byte_data;  last_byte <= byte_eof;
          crc <= crc_step(CRC_SEED, byte_data);
          sh <= FLAG;  bi <= '0;  ones <= '0;  acc <= '0;  cnt <= '0;
          st <= S_OPEN;
        end
        S_LOAD: if (byte_valid) begin
          sh <= byte_data;  last_byte <= byte_eof;
          crc <= crc_step(crc, byte_data);
          st <= S_DATA;
        end
        S_OPEN:   if (last) begin sh <= first_byte; st <= S_DATA; end
        S_DATA:   if (last) begin
          if (last_byte) begin sh <= ~crc[7:0]; st <= S_CHK_LO; end
          else st <= S_LOAD;
        end
        S_CHK_LO: if (last) begin sh <= ~crc[15:8]; st <= S_CHK_HI; end
        S_CHK_HI: if (last) begin sh <= FLAG; st <= S_CLOSE; end
        S_CLOSE:  if (last) st <= full ? S_IDLE : S_PAD;
        S_PAD: begin
          oct_valid <= 1'b1;  oct_data <= pad_val;
          cnt <= '0;  acc <= '0;  st <= S_EXTRA;
        end
        S_EXTRA: begin
          oct_valid <= 1'b1;  oct_data <= 8'hFF;  st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !oct_valid |-> (oct_data == 8'hFF));
  assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_MAX);
  assert_octet_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < OCT8) && (!m56 || cnt < OCT7));
  assert_top_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_valid && m56) |-> oct_data[7]);
  assert_extra_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAD) |=> ##1 (oct_valid && oct_data == 8'hFF));
  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && byte_valid && byte_sof) |=> !byte_ready);
endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_56k = 1'b0, byte_valid = 1'b0, byte_sof = 1'b0, byte_eof = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_ready, oct_valid;
  logic [7:0] oct_data;

  hdlc_tx_framer u0 (.clk(clk), .rst_n(rst_n), .mode_56k(mode_56k),
    .byte_valid(byte_valid), .byte_sof(byte_sof), .byte_eof(byte_eof),
    .byte_data(byte_data), .byte_ready(byte_ready), .oct_valid(oct_valid),
    .oct_data(oct_data));

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, idle_bad = 0, cap_n = 0, exp_n = 0, ready_cap = 0;
  bit fin = 1'b0, exp_pad = 1'b0;
  logic [7:0] cap [0:1023];
  logic [7:0] exp_o [0:255];
  logic [7:0] frm [0:15];

  always @(negedge clk) if (rst_n) begin
    if (oct_valid) begin
      if (cap_n < 1024) cap[cap_n] = oct_data;
      cap_n = cap_n + 1;
    end else if (oct_data != 8'hFF) idle_bad = idle_bad + 1;
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 50000 && !fin) begin
      fin = 1'b1; checks++; errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int j = 0; j < 8; j++) begin
      if (r[0] ^ d[j]) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  // Bit-level model: appends the expected octets of one frame to exp_o
  task automatic model_frame(input bit m, input int n);
    bit bb [0:1023];
    int nb = 0, ones = 0, k = 0, per;
    logic [15:0] c = 16'hFFFF;
    logic [7:0] v, o;
    for (int i = 0; i < n; i++) c = ref_crc(c, frm[i]);
    for (int j = 0; j < 8; j++) bb[nb++] = 1'(8'h7E >> j);
    for (int i = 0; i < n + 2; i++) begin
      v = (i < n) ? frm[i] : ((i == n) ? ~c[7:0] : ~c[15:8]);
      for (int j = 0; j < 8; j++) begin
        bb[nb++] = v[j];
        ones = v[j] ? ones + 1 : 0;
        if (ones == 5) begin bb[nb++] = 1'b0; ones = 0; end
      end
    end
    for (int j = 0; j < 8; j++) bb[nb++] = 1'(8'h7E >> j);
    per = m ? 7 : 8;
    while (k + per <= nb) begin
      o = 8'hFF;
      for (int j = 0; j < per; j++) o[j] = bb[k + j];
      exp_o[exp_n++] = o;
      k += per;
    end
    exp_pad = (k < nb);
    if (k < nb) begin
      o = 8'hFF;
      for (int j = 0; j < nb - k; j++) o[j] = bb[k + j];
      exp_o[exp_n++] = o;
      exp_o[exp_n++] = 8'hFF;
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = d; byte_sof = s; byte_eof = e;
    #1;
    while (!byte_ready) begin @(negedge clk); #1; end
    ready_cap = cap_n;
    @(posedge clk);
  endtask

  task automatic send_frame(input bit m, input int n, input int gap, input bit drop);
    mode_56k = m;
    for (int i = 0; i < n; i++) begin
      send_byte(frm[i], i == 0, i == n - 1);
      if (i < n - 1)
        for (int g = 0; g < gap; g++) begin @(negedge clk); byte_valid = 1'b0; end
    end
    if (drop) begin @(negedge clk); byte_valid = 1'b0; byte_sof = 1'b0; byte_eof = 1'b0; end
  endtask

  task automatic wait_done();
    do begin @(negedge clk); #1; end while (!byte_ready);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input int base, input string req);
    chk(cap_n - base == exp_n, req, cap_n - base, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(cap[base + i] == exp_o[i], req, cap[base + i], exp_o[i]);
  endtask

  task automatic t_reset();
    chk(byte_ready == 1'b1, "R1 ready after reset", byte_ready, 1);
    chk(oct_valid == 1'b0, "R1 no strobe after reset", oct_valid, 0);
    chk(oct_data == 8'hFF, "R1 idle octet", oct_data, 8'hFF);
  endtask

  task automatic t_basic64();
    int base = cap_n;
    frm[0] = 8'h12; frm[1] = 8'h34; frm[2] = 8'hA5;
    exp_n = 0; model_frame(1'b0, 3);
    send_frame(1'b0, 3, 0, 1'b1); wait_done();
    chk(cap[base] == 8'h7E, "R2 opening flag octet", cap[base], 8'h7E);
    compare(base, "R3 R5 R6 64k frame");
  endtask

  task automatic t_stuff();
    int base = cap_n;
    frm[0] = 8'hFF; frm[1] = 8'hFF; frm[2] = 8'hFF; frm[3] = 8'h1F; frm[4] = 8'hF8;
    exp_n = 0; model_frame(1'b0, 5);
    send_frame(1'b0, 5, 0, 1'b1); wait_done();
    compare(base, "R4 R11 stuffed 64k frame");
  endtask

  task automatic t_56k();
    int base = cap_n;
    frm[0] = 8'hFF; frm[1] = 8'h55; frm[2] = 8'h00; frm[3] = 8'h7E;
    exp_n = 0; model_frame(1'b1, 4);
    send_frame(1'b1, 4, 0, 1'b1); wait_done();
    compare(base, "R7 R11 56k frame");
    for (int i = base; i < cap_n; i++) chk(cap[i][7], "R7 top bit set", cap[i], 8'h80);
  endtask

  task automatic t_pad();
    int base = cap_n;
    frm[0] = 8'h00;
    exp_n = 0; model_frame(1'b1, 1);
    send_frame(1'b1, 1, 0, 1'b1); wait_done();
    compare(base, "R8 padded 56k frame");
    if (exp_pad) chk(cap[cap_n - 1] == 8'hFF, "R8 extra ones octet", cap[cap_n - 1], 8'hFF);
    base = cap_n;
    frm[0] = 8'h3C; frm[1] = 8'h81;
    exp_n = 0; model_frame(1'b0, 2);
    send_frame(1'b0, 2, 0, 1'b1); wait_done();
    compare(base, "R8 frame end handling 64k");
  endtask

  task automatic t_gap();
    int base = cap_n;
    frm[0] = 8'h12; frm[1] = 8'h34; frm[2] = 8'hA5; frm[3] = 8'hF0;
    exp_n = 0; model_frame(1'b0, 4);
    send_frame(1'b0, 4, 5, 1'b1); wait_done();
    compare(base, "R10 paused input");
  endtask

  task automatic t_back2back();
    int base = cap_n, na;
    frm[0] = 8'hC3; frm[1] = 8'h3C;
    exp_n = 0; model_frame(1'b0, 2);
    na = exp_n;
    send_frame(1'b0, 2, 0, 1'b0);
    frm[0] = 8'hAA;
    model_frame(1'b1, 1);
    send_frame(1'b1, 1, 0, 1'b1);
    chk(ready_cap - base == na, "R9 next frame taken after last octet", ready_cap - base, na);
    wait_done();
    compare(base, "R9 R7 back-to-back frames");
  endtask

  task automatic t_stray();
    int base = cap_n;
    @(negedge clk);
    byte_valid = 1'b1; byte_sof = 1'b0; byte_eof = 1'b1; byte_data = 8'h99;
    repeat (5) @(negedge clk);
    byte_valid = 1'b0; byte_eof = 1'b0;
    repeat (40) @(negedge clk);
    #1;
    chk(cap_n == base, "R12 stray byte dropped", cap_n - base, 0);
    chk(byte_ready == 1'b1, "R12 still idle", byte_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_basic64();
    t_stuff();
    t_56k();
    t_pad();
    t_gap();
    t_back2back();
    t_stray();
    chk(idle_bad == 0, "R1 idle octets are 0xFF", idle_bad, 0);
    fin = 1'b1;
    report();
  end
endmodule